// File: doc/BRIEF.md
# Scrambling Key Renewal Controller

This block holds the 128-bit scrambling key and 128-bit nonce that a memory cipher uses. When software pulses a renew request, the controller asks a key-provisioning agent for fresh material over a four-phase req/ack port. It captures the returned key, nonce and seed-provenance flag, and reports progress through status bits. While a request is outstanding, memory transactions are held off, so no access ever runs with a key that is half replaced.

The key port follows these back-pressure rules. The controller raises `key_req_o` and keeps it high for as long as the agent needs. The cycle in which `key_ack_i` is sampled high is the only cycle in which the data lines are read. `key_req_o` then falls. The controller treats the exchange as finished only after the agent has let `key_ack_i` fall again. An acknowledge that arrives with no request outstanding is ignored.

A multi-bit escalation input that carries any value other than its defined Off code puts the block into a terminal state. The key and nonce go back to their compile-time defaults, the valid flags clear, and memory access stays blocked until the next reset.

Top module: `scr_key_ctrl`

## Requirements
- R1: After reset, `key_o`/`nonce_o` equal the `DEF_KEY`/`DEF_NONCE` parameters, `key_req_o`, `busy_o`, `key_valid_o`, `seed_valid_o` and `escalated_o` are 0, and `allow_o` is 1.
- R2: A `renew_i` pulse while idle and not escalated makes `key_req_o` and `busy_o` 1, and `allow_o` 0, from the next cycle.
- R3: In the cycle after an accepted renew, `key_valid_o` and `seed_valid_o` read 0, even if they were 1 before.
- R4: `key_req_o` stays 1 until `key_ack_i` is sampled 1. On that edge `key_i`, `nonce_i` and `seed_valid_i` are captured. From the next cycle `key_req_o` is 0, `key_valid_o` is 1 and `allow_o` is 1.
- R5: `busy_o` stays 1 after the capture until `key_ack_i` is sampled 0, and is 0 from the following cycle.
- R6: A `renew_i` pulse while `busy_o` is 1 has no effect: no further request is raised once the current exchange ends.
- R7: `key_ack_i` with no request outstanding changes neither the key, the nonce nor the valid flags.
- R8: Any `esc_i` value other than `ESC_OFF` (default 4'b1010) sets `escalated_o` from the next cycle. In that same cycle the key and nonce are back at their defaults, both valid flags are 0, and `key_req_o` and `allow_o` are 0.
- R9: Escalation is terminal: `esc_i` returning to `ESC_OFF` and later `renew_i` pulses leave `escalated_o` at 1 and `key_req_o` and `allow_o` at 0.
- R10: `status_o` bit 2 is `escalated_o`, bit 3 is `key_valid_o` and bit 4 is `seed_valid_o`. Bits 0, 1 and 5 belong to other blocks and read 0.
- R11: If escalation and an acknowledge arrive in the same cycle, escalation wins and the returned key is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| renew_i | input | 1 | Single-cycle request for new key material |
| key_req_o | output | 1 | Key request to the provisioning agent |
| key_ack_i | input | 1 | Acknowledge from the agent; data valid while high |
| key_i | input | KEY_W | Returned key |
| nonce_i | input | NONCE_W | Returned nonce |
| seed_valid_i | input | 1 | Returned key derives from a provisioned seed |
| esc_i | input | ESC_W | Multi-bit escalation code |
| key_o | output | KEY_W | Current key |
| nonce_o | output | NONCE_W | Current nonce |
| key_valid_o | output | 1 | Key obtained and current |
| seed_valid_o | output | 1 | Current key came from a provisioned seed |
| escalated_o | output | 1 | Terminal escalation state |
| busy_o | output | 1 | Key exchange in progress |
| allow_o | output | 1 | Memory transactions permitted |
| status_o | output | 6 | Status word, see R10 |

## Verification
A wrong handshake phase appears at the ports within one cycle. A request that never drops shows up as `allow_o` stuck low after the acknowledge. A lost phase shows up as `busy_o` falling before `key_ack_i` does, or as a second request raised by a renew that should have been ignored. A wrongly latched key or nonce appears on `key_o`/`nonce_o` in the cycle after the acknowledge, and a stray acknowledge that leaks through appears in that same cycle. A leaky escalation latch is caught by renewing after `esc_i` has returned to Off and watching `key_req_o` and `allow_o`.

// File: rtl/scr_key_pkg.sv
package scr_key_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_REQ     = 2'd1,
    PH_RELEASE = 2'd2,
    PH_LOCKED  = 2'd3
  } scr_phase_e;

  localparam int unsigned ST_W      = 6;
  localparam int unsigned ST_ESC    = 2;
  localparam int unsigned ST_KVALID = 3;
  localparam int unsigned ST_SEED   = 4;

endpackage

// File: rtl/scr_esc_latch.sv
module scr_esc_latch #(
  parameter int unsigned    ESC_W   = 4,
  parameter logic [ESC_W-1:0] ESC_OFF = 4'b1010
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ESC_W-1:0] esc_i,
  output logic             esc_hit_o,
  output logic             escalated_o
);

  // Anything that is not the exact Off code counts as an escalation.
  assign esc_hit_o = (esc_i != ESC_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) escalated_o <= 1'b0;
    else if (esc_hit_o) escalated_o <= 1'b1;
  end

endmodule

// File: rtl/scr_req_fsm.sv
module scr_req_fsm
  import scr_key_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic renew_i,
  input  logic ack_i,
  input  logic kill_i,
  output logic req_o,
  output logic busy_o,
  output logic start_o,
  output logic capture_o
);

  scr_phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:    if (kill_i) phase_d = PH_LOCKED;
                  else if (renew_i) phase_d = PH_REQ;
      PH_REQ:     if (kill_i) phase_d = PH_LOCKED;
                  else if (ack_i) phase_d = PH_RELEASE;
      PH_RELEASE: if (kill_i) phase_d = PH_LOCKED;
                  else if (!ack_i) phase_d = PH_IDLE;
      PH_LOCKED:  phase_d = PH_LOCKED;
      default:    phase_d = PH_LOCKED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign req_o     = (phase_q == PH_REQ);
  assign busy_o    = (phase_q == PH_REQ) || (phase_q == PH_RELEASE);
  assign start_o   = (phase_q == PH_IDLE) && renew_i && !kill_i;
  assign capture_o = (phase_q == PH_REQ) && ack_i && !kill_i;

endmodule

// File: rtl/scr_key_store.sv
module scr_key_store #(
  parameter int unsigned        KEY_W     = 128,
  parameter int unsigned        NONCE_W   = 128,
  parameter logic [KEY_W-1:0]   DEF_KEY   = '0,
  parameter logic [NONCE_W-1:0] DEF_NONCE = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               capture_i,
  input  logic               wipe_i,
  input  logic [KEY_W-1:0]   key_i,
  input  logic [NONCE_W-1:0] nonce_i,
  input  logic               seed_valid_i,
  output logic [KEY_W-1:0]   key_o,
  output logic [NONCE_W-1:0] nonce_o,
  output logic               key_valid_o,
  output logic               seed_valid_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_o   <= DEF_KEY;
      nonce_o <= DEF_NONCE;
    end else if (wipe_i) begin
      key_o   <= DEF_KEY;
      nonce_o <= DEF_NONCE;
    end else if (capture_i) begin
      key_o   <= key_i;
      nonce_o <= nonce_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_valid_o  <= 1'b0;
      seed_valid_o <= 1'b0;
    end else if (wipe_i || start_i) begin
      key_valid_o  <= 1'b0;
      seed_valid_o <= 1'b0;
    end else if (capture_i) begin
      key_valid_o  <= 1'b1;
      seed_valid_o <= seed_valid_i;
    end
  end

endmodule

// File: rtl/scr_key_ctrl.sv
module scr_key_ctrl
  import scr_key_pkg::*;
#(
  parameter int unsigned        KEY_W     = 128,
  parameter int unsigned        NONCE_W   = 128,
  parameter int unsigned        ESC_W     = 4,
  parameter logic [ESC_W-1:0]   ESC_OFF   = 4'b1010,
  parameter logic [KEY_W-1:0]   DEF_KEY   = '0,
  parameter logic [NONCE_W-1:0] DEF_NONCE = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               renew_i,
  output logic               key_req_o,
  input  logic               key_ack_i,
  input  logic [KEY_W-1:0]   key_i,
  input  logic [NONCE_W-1:0] nonce_i,
  input  logic               seed_valid_i,
  input  logic [ESC_W-1:0]   esc_i,
  output logic [KEY_W-1:0]   key_o,
  output logic [NONCE_W-1:0] nonce_o,
  output logic               key_valid_o,
  output logic               seed_valid_o,
  output logic               escalated_o,
  output logic               busy_o,
  output logic               allow_o,
  output logic [ST_W-1:0]    status_o
);

  logic esc_hit, kill, start, capture;

  scr_esc_latch #(.ESC_W(ESC_W), .ESC_OFF(ESC_OFF)) u_esc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .esc_i       (esc_i),
    .esc_hit_o   (esc_hit),
    .escalated_o (escalated_o)
  );

  assign kill = esc_hit || escalated_o;

  scr_req_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .renew_i   (renew_i),
    .ack_i     (key_ack_i),
    .kill_i    (kill),
    .req_o     (key_req_o),
    .busy_o    (busy_o),
    .start_o   (start),
    .capture_o (capture)
  );

  scr_key_store #(
    .KEY_W(KEY_W), .NONCE_W(NONCE_W), .DEF_KEY(DEF_KEY), .DEF_NONCE(DEF_NONCE)
  ) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .capture_i    (capture),
    .wipe_i       (kill),
    .key_i        (key_i),
    .nonce_i      (nonce_i),
    .seed_valid_i (seed_valid_i),
    .key_o        (key_o),
    .nonce_o      (nonce_o),
    .key_valid_o  (key_valid_o),
    .seed_valid_o (seed_valid_o)
  );

  // Traffic is held only while a request is open or after escalation.
  assign allow_o = !key_req_o && !escalated_o;

  always_comb begin
    status_o            = '0;
    status_o[ST_ESC]    = escalated_o;
    status_o[ST_KVALID] = key_valid_o;
    status_o[ST_SEED]   = seed_valid_o;
  end

endmodule

// File: rtl/scr_key_ctrl_chk.sv
module scr_key_ctrl_chk #(
  parameter int unsigned        KEY_W     = 128,
  parameter int unsigned        ESC_W     = 4,
  parameter logic [ESC_W-1:0]   ESC_OFF   = 4'b1010,
  parameter logic [KEY_W-1:0]   DEF_KEY   = '0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             renew_i,
  input logic             key_req_o,
  input logic             key_ack_i,
  input logic [ESC_W-1:0] esc_i,
  input logic [KEY_W-1:0] key_o,
  input logic             key_valid_o,
  input logic             escalated_o,
  input logic             busy_o,
  input logic             allow_o
);

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_req_o && !key_ack_i && esc_i == ESC_OFF |=> key_req_o); // R4

  AST_VALID_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_req_o && key_ack_i && esc_i == ESC_OFF |=> key_valid_o && !key_req_o); // R4

  AST_RENEW_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    renew_i && !busy_o && !escalated_o && esc_i == ESC_OFF |=> key_req_o && !key_valid_o); // R3

  AST_STRAY_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_req_o && esc_i == ESC_OFF |=> $stable(key_o)); // R7

  AST_ESC_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc_i != ESC_OFF |=> escalated_o && key_o == DEF_KEY && !key_valid_o); // R8

  AST_ESC_TERMINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    escalated_o |=> escalated_o && !key_req_o && !allow_o); // R9

endmodule

bind scr_key_ctrl scr_key_ctrl_chk #(
  .KEY_W(KEY_W), .ESC_W(ESC_W), .ESC_OFF(ESC_OFF), .DEF_KEY(DEF_KEY)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .renew_i     (renew_i),
  .key_req_o   (key_req_o),
  .key_ack_i   (key_ack_i),
  .esc_i       (esc_i),
  .key_o       (key_o),
  .key_valid_o (key_valid_o),
  .escalated_o (escalated_o),
  .busy_o      (busy_o),
  .allow_o     (allow_o)
);

// File: tb/scr_key_ctrl_bench.sv
module scr_key_ctrl_bench;

  localparam logic [127:0] DK = 128'hA5A5_0001_A5A5_0002_A5A5_0003_A5A5_0004;
  localparam logic [127:0] DN = 128'h5A5A_1000_5A5A_2000_5A5A_3000_5A5A_4000;
  localparam logic [127:0] K1 = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
  localparam logic [127:0] N1 = 128'h0F0F_0F0F_0F0F_0F0F_0F0F_0F0F_0F0F_0F0F;
  localparam logic [127:0] K2 = 128'hDEAD_BEEF_CAFE_F00D_0123_4567_89AB_CDEF;
  localparam logic [127:0] N2 = 128'hFEDC_BA98_7654_3210_1357_9BDF_2468_ACE0;
  localparam logic [127:0] K3 = 128'h9999_9999_9999_9999_9999_9999_9999_9999;
  localparam logic [3:0]   OFF = 4'b1010;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         renew = 1'b0;
  logic         ack = 1'b0;
  logic [127:0] kin = '0;
  logic [127:0] nin = '0;
  logic         sin = 1'b0;
  logic [3:0]   esc = OFF;
  logic         req, kval, sval, escd, busy, allow;
  logic [127:0] kout, nout;
  logic [5:0]   st;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  scr_key_ctrl #(.DEF_KEY(DK), .DEF_NONCE(DN)) u_scr_key_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .renew_i(renew), .key_req_o(req),
    .key_ack_i(ack), .key_i(kin), .nonce_i(nin), .seed_valid_i(sin),
    .esc_i(esc), .key_o(kout), .nonce_o(nout), .key_valid_o(kval),
    .seed_valid_o(sval), .escalated_o(escd), .busy_o(busy),
    .allow_o(allow), .status_o(st)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; renew = 0; ack = 0; esc = OFF;
    step(2);
    rst_n = 1'b1;
    step(1);
    check("R1 key", kout, DK);
    check("R1 nonce", nout, DN);
    check("R1 req/busy/valid/seed/esc", {req, busy, kval, sval, escd}, 5'b0);
    check("R1 allow", allow, 1);
    check("R10 status reset", st, 6'b0);
  endtask

  task automatic pulse_renew();
    renew = 1'b1; step(1); renew = 1'b0;
  endtask

  task automatic t_first_key();
    pulse_renew();
    check("R2 req", req, 1);
    check("R2 busy", busy, 1);
    check("R2 allow", allow, 0);
    step(3);
    check("R4 req held", req, 1);
    check("R4 key unchanged before ack", kout, DK);
    kin = K1; nin = N1; sin = 1'b1; ack = 1'b1;
    step(1);
    check("R4 req dropped", req, 0);
    check("R4 key", kout, K1);
    check("R4 nonce", nout, N1);
    check("R4 valid+seed", {kval, sval}, 2'b11);
    check("R4 allow", allow, 1);
    step(2);
    check("R5 busy while ack high", busy, 1);
    ack = 1'b0; kin = K3;
    step(1);
    check("R5 busy cleared", busy, 0);
    check("R10 status", st, 6'b011000);
  endtask

  task automatic t_second_key();
    pulse_renew();
    check("R3 valid cleared", {kval, sval}, 2'b00);
    check("R3 key kept", kout, K1);
    step(1);
    pulse_renew();                // while REQ: ignored
    check("R6 req during pending", req, 1);
    kin = K2; nin = N2; sin = 1'b0; ack = 1'b1;
    step(1);
    check("R4 second key", kout, K2);
    check("R4 seed low", {kval, sval}, 2'b10);
    pulse_renew();                // while RELEASE: ignored
    ack = 1'b0;
    step(1);
    check("R5 idle", busy, 0);
    step(3);
    check("R6 no second request", req, 0);
    check("R6 valid kept", kval, 1);
  endtask

  task automatic t_stray_ack();
    kin = K3; nin = K3; sin = 1'b1; ack = 1'b1;
    step(2);
    ack = 1'b0;
    step(1);
    check("R7 key", kout, K2);
    check("R7 nonce", nout, N2);
    check("R7 flags", {kval, sval, req}, 3'b100);
  endtask

  task automatic t_escalate_with_ack();
    pulse_renew();
    step(1);
    kin = K1; nin = N1; sin = 1'b1; ack = 1'b1; esc = 4'b0000;
    step(1);
    ack = 1'b0; esc = OFF;
    check("R8 escalated", escd, 1);
    check("R11 key default", kout, DK);
    check("R11 nonce default", nout, DN);
    check("R8 flags", {kval, sval, req, allow}, 4'b0);
    check("R10 status esc", st, 6'b000100);
    pulse_renew();
    step(3);
    check("R9 terminal", {escd, req, allow, busy}, 4'b1000);
  endtask

  task automatic t_escalate_near_off();
    esc = 4'b1011;
    step(1);
    esc = OFF;
    check("R8 near-off code", escd, 1);
    check("R8 allow", allow, 0);
    step(2);
    check("R9 stays", escd, 1);
  endtask

  initial begin
    step(1);
    do_reset();
    t_first_key();
    t_second_key();
    t_stray_ack();
    t_escalate_with_ack();
    do_reset();
    t_escalate_near_off();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule